// File: doc/BRIEF.md
# Edge Interrupt and Wake Detector

This block watches a bank of already-synchronized input levels and turns their transitions into pending events. For every input there are two interrupt enables, one for rising and one for falling transitions. Setting both makes the input trigger on either edge. A qualifying edge latches a bit in the interrupt status register. While any such bit is pending, the single combined interrupt output stays high. A handler reads the status, services the pins starting from bit 0, and acknowledges them by writing ones to the clear register.

A second, independent pair of enables selects which edges count as wake events. A wake event is accepted only for a pin whose sleep-control bit is 0; a 1 blocks wakeup for that pin. Accepted wake events latch in a wake status register, and the wake request output stays high while any of those bits is set. The one clear register acknowledges both status registers.

The block detects edges only; it has no level-sensitive mode. Configuration uses a simple register port: a write strobe with its address and data, plus a read address whose data returns one cycle later.

Top module: `edge_wake_detector`

## Requirements
- R1: After a synchronous reset, every register reads 0 and both irq_o and wake_o are low. Addresses are: 0 rising interrupt enable, 1 falling interrupt enable, 2 rising wake enable, 3 falling wake enable, 4 sleep control, 5 interrupt status, 6 clear, 7 wake status.
- R2: A 0-to-1 change on pin n while bit n of the rising interrupt enable (address 0) is 1 sets bit n of the interrupt status (address 5) at the same clock edge that samples the new level. irq_o is high from that edge for as long as any interrupt status bit is 1.
- R3: A 1-to-0 change on pin n while bit n of the falling interrupt enable (address 1) is 1 sets interrupt status bit n. With both enables set, either direction sets the bit.
- R4: An edge whose direction has its enable bit at 0 does not change the interrupt status.
- R5: Writing address 6 clears every interrupt status bit whose data bit is 1 and leaves bits written with 0 unchanged. irq_o drops once no bit remains set. Reads of address 6 return 0.
- R6: When an edge sets a status bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R7: A rising edge with rising wake enable bit n (address 2) at 1, or a falling edge with falling wake enable bit n (address 3) at 1, sets wake status bit n (address 7), provided sleep control bit n (address 4) is 0. wake_o is high while any wake status bit is 1.
- R8: While sleep control bit n is 1, no edge on pin n sets wake status bit n.
- R9: The clear write at address 6 also clears the wake status bits whose data bit is 1, and wake_o drops when none remain.
- R10: Interrupt enables affect only the interrupt status and wake enables affect only the wake status.
- R11: Addresses 0 to 4 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | WIDTH | Synchronized input levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | WIDTH | Read data, registered, valid one cycle after rd_addr |
| irq_o | output | 1 | Combined interrupt, high while any interrupt status bit is set |
| wake_o | output | 1 | Wake request, high while any wake status bit is set |

## Verification
The hardest situation to reach is a pin edge that lands in exactly the cycle in which a clear write targets the same status bit. The stimulus gets there with one task that changes the pin level and raises the clear strobe at the same falling clock edge. A variant of that collision runs on the wake side, where one pin's bit is being cleared while a different pin's bit is being set. That variant shows that the clear touches only its masked bits. The sleep gate also needs care. A wake enable is armed on two pins, one of which is blocked by its sleep bit. Both pins toggle together, and only the unblocked pin may show up in the wake status.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_CFG = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RISE_IRQ  = 3'd0,
    SEL_FALL_IRQ  = 3'd1,
    SEL_RISE_WAKE = 3'd2,
    SEL_FALL_WAKE = 3'd3,
    SEL_SLEEP     = 3'd4,
    SEL_IRQ_STAT  = 3'd5,
    SEL_CLEAR     = 3'd6,
    SEL_WAKE_STAT = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ewd_edge_detect.sv
module ewd_edge_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] lvl_d;

  // During reset the history follows the input, so no edge appears at release.
  always_ff @(posedge clk) begin
    lvl_d <= lvl;
  end

  always_comb begin
    if (rst) begin
      rise = '0;
      fall = '0;
    end else begin
      rise = lvl & ~lvl_d;
      fall = ~lvl & lvl_d;
    end
  end
endmodule

// File: rtl/ewd_cfg_regs.sv
module ewd_cfg_regs
  import ewd_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rise_irq_en,
  output logic [WIDTH-1:0]  fall_irq_en,
  output logic [WIDTH-1:0]  rise_wake_en,
  output logic [WIDTH-1:0]  fall_wake_en,
  output logic [WIDTH-1:0]  sleep_ctl,
  output logic [WIDTH-1:0]  clr_mask
);
  logic [WIDTH-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        cfg_q[g] <= wr_data;
      end
    end
  end

  assign rise_irq_en  = cfg_q[SEL_RISE_IRQ];
  assign fall_irq_en  = cfg_q[SEL_FALL_IRQ];
  assign rise_wake_en = cfg_q[SEL_RISE_WAKE];
  assign fall_wake_en = cfg_q[SEL_FALL_WAKE];
  assign sleep_ctl    = cfg_q[SEL_SLEEP];

  // Write-one-to-clear strobe, one cycle wide
  assign clr_mask = (wr_en && (wr_addr == SEL_CLEAR)) ? wr_data : '0;
endmodule

// File: rtl/ewd_event_latch.sv
module ewd_event_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] stat_q,
  output logic             any_q
);
  logic [WIDTH-1:0] stat_d;

  // A new event outranks an acknowledge in the same cycle.
  assign stat_d = (stat_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      any_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      any_q  <= |stat_d;
    end
  end
endmodule

// File: rtl/edge_wake_detector.sv
module edge_wake_detector
  import ewd_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  pin_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              irq_o,
  output logic              wake_o
);
  logic [WIDTH-1:0] rise, fall;
  logic [WIDTH-1:0] rise_irq_en, fall_irq_en, rise_wake_en, fall_wake_en;
  logic [WIDTH-1:0] sleep_ctl, clr_mask;
  logic [WIDTH-1:0] irq_set, wake_set;
  logic [WIDTH-1:0] irq_stat, wake_stat;
  logic [WIDTH-1:0] rd_mux;

  ewd_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_lvl),
    .rise (rise),
    .fall (fall)
  );

  ewd_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rise_irq_en  (rise_irq_en),
    .fall_irq_en  (fall_irq_en),
    .rise_wake_en (rise_wake_en),
    .fall_wake_en (fall_wake_en),
    .sleep_ctl    (sleep_ctl),
    .clr_mask     (clr_mask)
  );

  assign irq_set  = (rise & rise_irq_en) | (fall & fall_irq_en);
  // A sleep-control bit of 0 lets wake events through.
  assign wake_set = ((rise & rise_wake_en) | (fall & fall_wake_en)) & ~sleep_ctl;

  ewd_event_latch #(.WIDTH(WIDTH)) u_irq_lat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (irq_set),
    .clr_vec (clr_mask),
    .stat_q  (irq_stat),
    .any_q   (irq_o)
  );

  ewd_event_latch #(.WIDTH(WIDTH)) u_wake_lat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (wake_set),
    .clr_vec (clr_mask),
    .stat_q  (wake_stat),
    .any_q   (wake_o)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_RISE_IRQ:  rd_mux = rise_irq_en;
      SEL_FALL_IRQ:  rd_mux = fall_irq_en;
      SEL_RISE_WAKE: rd_mux = rise_wake_en;
      SEL_FALL_WAKE: rd_mux = fall_wake_en;
      SEL_SLEEP:     rd_mux = sleep_ctl;
      SEL_IRQ_STAT:  rd_mux = irq_stat;
      SEL_WAKE_STAT: rd_mux = wake_stat;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/ewd_checker.sv
module ewd_checker
  import ewd_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  pin_lvl,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [WIDTH-1:0]  rise_irq_en,
  input logic [WIDTH-1:0]  fall_irq_en,
  input logic [WIDTH-1:0]  rise_wake_en,
  input logic [WIDTH-1:0]  fall_wake_en,
  input logic [WIDTH-1:0]  sleep_ctl,
  input logic [WIDTH-1:0]  irq_stat,
  input logic [WIDTH-1:0]  wake_stat,
  input logic              irq_o,
  input logic              wake_o
);
  logic [WIDTH-1:0] pin_prev, up, dn, clr, exp_irq, exp_wake;
  logic [WIDTH-1:0] irq_set_q, wake_set_q, irq_drop_q, wake_drop_q;
  logic [WIDTH-1:0] irq_prev_q, wake_prev_q;

  assign up       = pin_lvl & ~pin_prev;
  assign dn       = ~pin_lvl & pin_prev;
  assign clr      = (wr_en && wr_addr == SEL_CLEAR) ? wr_data : '0;
  assign exp_irq  = (up & rise_irq_en) | (dn & fall_irq_en);
  assign exp_wake = ((up & rise_wake_en) | (dn & fall_wake_en)) & ~sleep_ctl;

  always_ff @(posedge clk) begin
    pin_prev <= pin_lvl;
    if (rst) begin
      irq_set_q   <= '0;
      wake_set_q  <= '0;
      irq_drop_q  <= '0;
      wake_drop_q <= '0;
      irq_prev_q  <= '0;
      wake_prev_q <= '0;
    end else begin
      irq_set_q   <= exp_irq;
      wake_set_q  <= exp_wake;
      irq_drop_q  <= clr & ~exp_irq;
      wake_drop_q <= clr & ~exp_wake;
      irq_prev_q  <= irq_stat;
      wake_prev_q <= wake_stat;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq_stat == '0 && wake_stat == '0 && !irq_o && !wake_o));

  // R2, R3, R6: an enabled edge is latched even against a clear
  a_r2_irq_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & irq_set_q) == irq_set_q);

  a_r4_no_stray_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & ~irq_prev_q & ~irq_set_q) == '0);

  a_r5_clear_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & irq_drop_q) == '0);

  a_r2_irq_line: assert property (@(posedge clk) disable iff (rst)
    irq_o == (irq_stat != '0));

  a_r7_wake_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (wake_stat & wake_set_q) == wake_set_q);

  // R8 and R10: wake bits rise only from qualified wake events
  a_r8_no_stray_wake: assert property (@(posedge clk) disable iff (rst)
    (wake_stat & ~wake_prev_q & ~wake_set_q) == '0);

  a_r9_clear_wake: assert property (@(posedge clk) disable iff (rst)
    (wake_stat & wake_drop_q) == '0);

  a_r7_wake_line: assert property (@(posedge clk) disable iff (rst)
    wake_o == (wake_stat != '0));
endmodule

bind edge_wake_detector ewd_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pin_lvl      (pin_lvl),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rise_irq_en  (rise_irq_en),
  .fall_irq_en  (fall_irq_en),
  .rise_wake_en (rise_wake_en),
  .fall_wake_en (fall_wake_en),
  .sleep_ctl    (sleep_ctl),
  .irq_stat     (irq_stat),
  .wake_stat    (wake_stat),
  .irq_o        (irq_o),
  .wake_o       (wake_o)
);

// File: tb/edge_wake_detector_test.sv
`timescale 1ns/1ps
module edge_wake_detector_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_lvl = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         irq_o, wake_o;

  int checks = 0;
  int fails  = 0;
  logic rd_req = 1'b0;
  logic rd_req_d = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  edge_wake_detector #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when registered read data is valid
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: read with empty queue");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // Driver: issues a read and pushes its expected value
  task automatic rd(logic [2:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    rd_req  = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req  = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins(logic [W-1:0] v);
    @(negedge clk);
    pin_lvl = v;
    @(negedge clk);
  endtask

  // Pin change and clear write land in the same cycle
  task automatic pins_clear(logic [W-1:0] v, logic [W-1:0] c);
    @(negedge clk);
    pin_lvl = v;
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), '0, $sformatf("R1 reg %0d", a));
    check("R1 irq_o", W'(irq_o), '0);
    check("R1 wake_o", W'(wake_o), '0);

    wr(3'd0, 32'h5);
    wr(3'd1, 32'h6);
    rd(3'd0, 32'h5, "R11 rise irq en");
    rd(3'd1, 32'h6, "R11 fall irq en");

    pins(32'h1);
    check("R2 irq_o after rise", W'(irq_o), 1);
    rd(3'd5, 32'h1, "R2 rise pin0");
    pins(32'h3);
    rd(3'd5, 32'h1, "R4 rise pin1 not enabled");
    pins(32'h1);
    rd(3'd5, 32'h3, "R3 fall pin1");
    pins(32'h5);
    rd(3'd5, 32'h7, "R2 rise pin2");
    wr(3'd6, 32'h4);
    rd(3'd5, 32'h3, "R5 partial clear");
    check("R5 irq_o held", W'(irq_o), 1);
    pins(32'h1);
    rd(3'd5, 32'h7, "R3 both edges pin2");
    rd(3'd7, 32'h0, "R10 irq enables leave wake status");
    rd(3'd6, 32'h0, "R5 clear reads zero");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd5, 32'h0, "R5 clear all");
    check("R5 irq_o low", W'(irq_o), 0);
    pins(32'h101);
    rd(3'd5, 32'h0, "R4 pin8 no enable");
    pins(32'h100);
    rd(3'd5, 32'h0, "R4 pin0 fall no enable");
    pins_clear(32'h101, 32'h1);
    rd(3'd5, 32'h1, "R6 set beats clear");
    check("R6 irq_o", W'(irq_o), 1);
    wr(3'd6, 32'h1);

    wr(3'd2, 32'h30);
    wr(3'd3, 32'h10);
    wr(3'd4, 32'h20);
    rd(3'd2, 32'h30, "R11 rise wake en");
    rd(3'd3, 32'h10, "R11 fall wake en");
    rd(3'd4, 32'h20, "R11 sleep ctl");
    pins(32'h131);
    check("R7 wake_o", W'(wake_o), 1);
    rd(3'd7, 32'h10, "R8 pin5 blocked by sleep");
    rd(3'd5, 32'h0, "R10 wake enables leave irq status");
    pins(32'h121);
    rd(3'd7, 32'h10, "R7 fall pin4");
    wr(3'd6, 32'h10);
    rd(3'd7, 32'h0, "R9 wake clear");
    check("R9 wake_o low", W'(wake_o), 0);
    pins(32'h101);
    rd(3'd7, 32'h0, "R7 pin5 fall not enabled");
    wr(3'd4, 32'h0);
    pins(32'h121);
    rd(3'd7, 32'h20, "R7 pin5 rise sleep open");
    pins_clear(32'h131, 32'h20);
    rd(3'd7, 32'h10, "R9 clear pin5 while pin4 sets");
    check("R9 wake_o held", W'(wake_o), 1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule